// File: doc/BRIEF.md
# LFSR Keystream Cipher Endpoint

This block is a symmetric stream-cipher endpoint. Every accepted data word is XORed with a keystream word and the result is sent out one cycle later. The keystream word is the low `WORD_W` bits of an internal linear feedback shift register. The same module works as sender and as receiver, because XORing twice with the same keystream word gives back the original word. A sender and a receiver that hold the same seed produce the same sequence of keystream words.

The register moves forward by exactly one step for each word accepted on the input handshake. Idle cycles do not move it. A stream that is encrypted by one endpoint therefore decrypts correctly in a second endpoint that was seeded the same way, even when words arrive with gaps between them. A seed can be loaded at any time. Loading takes priority over data, and an all-zero seed is replaced by a fixed non-zero constant so that the register cannot get stuck at zero. `WORD_W` must not exceed `LFSR_W`. With the default 64-bit register and a maximal tap set, the sequence repeats only after 2^64 - 1 steps.

Top module: `keystream_cipher_port`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `in_ready` is 1 once reset is released, and the register holds `RESET_SEED`.
- R2: A word is accepted when `in_valid` and `in_ready` are both 1 at a rising edge. In the next cycle `out_valid` is 1 and `out_data` equals the accepted word XOR bits [WORD_W-1:0] of the register value at acceptance. In every cycle that follows a non-accepting edge, `out_valid` is 0.
- R3: Each accepted word moves the register one Fibonacci step: the state shifts left by one, and the new bit 0 is the XOR of the state bits whose positions are set in `TAP_MASK`. Cycles without an acceptance leave the state unchanged.
- R4: While `seed_load` is 1, `in_ready` is 0 and `in_valid` has no effect. After the edge, the register holds `seed_value` and no output word is produced.
- R5: Loading a `seed_value` of zero puts `FALLBACK_SEED` into the register, and the register never holds zero.
- R6: Two endpoints loaded with the same seed and connected output to input return every plaintext word bit-exactly, in order, whatever the stall pattern.
- R7: With an 8-bit register and `TAP_MASK` = 8'hB8 (bits 7, 5, 4, 3), starting from seed 8'h01, the state first returns to the seed after exactly 255 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_value` into the keystream register |
| seed_value | input | LFSR_W | Seed to load; zero is replaced by `FALLBACK_SEED` |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Endpoint can accept a word this cycle |
| in_data | input | WORD_W | Plaintext or ciphertext word |
| out_valid | output | 1 | One-cycle strobe marking a result word |
| out_data | output | WORD_W | Input word XOR keystream word |

## Verification
The bench builds the endpoint with `WORD_W` = `LFSR_W` = 8, `TAP_MASK` = 8'hB8 and non-default reset and fallback seeds. In that configuration a zero plaintext exposes the entire register state at `out_data`. This makes the full 255-step period and its first repeat observable in a few hundred cycles. An encrypting and a decrypting instance are chained under random stalls, and both are reseeded, including with zero. This checks lockstep advance, seed priority over data, and the zero-seed substitution against a behavioural model.

// File: rtl/ksx_pkg.sv
package ksx_pkg;

    // Action applied to the keystream register at a clock edge
    typedef enum logic [1:0] {
        LF_HOLD = 2'd0,
        LF_STEP = 2'd1,
        LF_LOAD = 2'd2
    } lf_op_e;

    // Seed loading wins over a data transfer
    function automatic lf_op_e pick_op(input logic load, input logic fire);
        if (load)      return LF_LOAD;
        else if (fire) return LF_STEP;
        else           return LF_HOLD;
    endfunction

endpackage

// File: rtl/ksx_state.sv
module ksx_state
    import ksx_pkg::*;
#(
    parameter int                LFSR_W        = 64,
    parameter logic [LFSR_W-1:0] TAP_MASK      = 64'hD800_0000_0000_0000,
    parameter logic [LFSR_W-1:0] RESET_SEED    = 64'h1,
    parameter logic [LFSR_W-1:0] FALLBACK_SEED = 64'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  lf_op_e            op,
    input  logic [LFSR_W-1:0] seed,
    output logic [LFSR_W-1:0] state_q
);

    logic              feedback;
    logic [LFSR_W-1:0] state_d;
    logic [LFSR_W-1:0] seed_safe;

    always_comb begin
        feedback  = ^(state_q & TAP_MASK);
        seed_safe = (seed == '0) ? FALLBACK_SEED : seed;
        unique case (op)
            LF_STEP: state_d = {state_q[LFSR_W-2:0], feedback};
            LF_LOAD: state_d = seed_safe;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RESET_SEED;
        else     state_q <= state_d;
    end

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        op == LF_HOLD |=> $stable(state_q));

    a_r3_shift_on_step: assert property (@(posedge clk) disable iff (rst)
        op == LF_STEP |=> state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0]));

    a_r4_seed_taken: assert property (@(posedge clk) disable iff (rst)
        (op == LF_LOAD && seed != '0) |=> state_q == $past(seed));

    a_r5_zero_replaced: assert property (@(posedge clk) disable iff (rst)
        (op == LF_LOAD && seed == '0) |=> state_q == FALLBACK_SEED);

endmodule

// File: rtl/ksx_mix.sv
module ksx_mix #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] key,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] dat;
    } beat_t;

    beat_t beat_q;
    beat_t beat_d;

    always_comb begin
        beat_d.vld = fire;
        beat_d.dat = fire ? (data ^ key) : beat_q.dat;
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign out_valid = beat_q.vld;
    assign out_data  = beat_q.dat;

    a_r2_no_spurious_word: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !out_valid);

endmodule

// File: rtl/keystream_cipher_port.sv
module keystream_cipher_port
    import ksx_pkg::*;
#(
    parameter int                WORD_W        = 16,
    parameter int                LFSR_W        = 64,
    parameter logic [LFSR_W-1:0] TAP_MASK      = 64'hD800_0000_0000_0000,
    parameter logic [LFSR_W-1:0] RESET_SEED    = 64'h0000_0000_0000_0001,
    parameter logic [LFSR_W-1:0] FALLBACK_SEED = 64'hACE1_5EED_0BAD_F00D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed_value,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    logic              fire;
    lf_op_e            op;
    logic [LFSR_W-1:0] state_q;
    logic [WORD_W-1:0] key;

    assign in_ready = !seed_load && !rst;
    assign fire     = in_valid && in_ready;
    assign op       = pick_op(seed_load, fire);
    assign key      = state_q[WORD_W-1:0];

    ksx_state #(
        .LFSR_W        (LFSR_W),
        .TAP_MASK      (TAP_MASK),
        .RESET_SEED    (RESET_SEED),
        .FALLBACK_SEED (FALLBACK_SEED)
    ) u_state (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .seed    (seed_value),
        .state_q (state_q)
    );

    ksx_mix #(
        .WORD_W (WORD_W)
    ) u_mix (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .data      (in_data),
        .key       (key),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    a_r2_word_follows_accept: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_valid && out_data == ($past(in_data) ^ $past(key))));

    a_r4_load_blocks_data: assert property (@(posedge clk) disable iff (rst)
        (seed_load && in_valid) |=> !out_valid);

    a_r5_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: tb/sim_keystream_cipher_port.sv
module sim_keystream_cipher_port;

    localparam int         CLK_PERIOD = 10;
    localparam int         W          = 8;
    localparam logic [7:0] TAPS       = 8'hB8;
    localparam logic [7:0] RST_SEED   = 8'h5A;
    localparam logic [7:0] FB_SEED    = 8'hC3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_load = 1'b0;
    logic [W-1:0] seed_value = '0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         u0_ready, u0_ov, u1_ready, u1_ov;
    logic [W-1:0] u0_od, u1_od;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [W-1:0] ref_state;
    logic [W-1:0] pt_q[$];
    bit           prev_fire = 1'b0;
    logic [W-1:0] last_od;

    always #(CLK_PERIOD/2) clk = ~clk;

    keystream_cipher_port #(
        .WORD_W(W), .LFSR_W(W), .TAP_MASK(TAPS),
        .RESET_SEED(RST_SEED), .FALLBACK_SEED(FB_SEED)
    ) u0 (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .in_valid(in_valid), .in_ready(u0_ready), .in_data(in_data),
        .out_valid(u0_ov), .out_data(u0_od)
    );

    keystream_cipher_port #(
        .WORD_W(W), .LFSR_W(W), .TAP_MASK(TAPS),
        .RESET_SEED(RST_SEED), .FALLBACK_SEED(FB_SEED)
    ) u1 (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .in_valid(u0_ov), .in_ready(u1_ready), .in_data(u0_od),
        .out_valid(u1_ov), .out_data(u1_od)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=50000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
        logic fb = 1'b0;
        for (int i = 0; i < W; i++) if (TAPS[i]) fb ^= s[i];
        return {s[W-2:0], fb};
    endfunction

    // One clock: drive at the falling edge, predict, then compare at the next falling edge
    task automatic cycle(input logic v, input logic [W-1:0] d, input logic ld,
                         input logic [W-1:0] sd);
        logic         fire;
        logic [W-1:0] exp_d;
        logic [W-1:0] pt;
        in_valid   = v;
        in_data    = d;
        seed_load  = ld;
        seed_value = sd;
        #1;
        check(u0_ready == !ld, "R4 in_ready", {63'd0, u0_ready}, {63'd0, !ld});
        fire  = v && !ld;
        exp_d = d ^ ref_state;
        if (ld)        ref_state = (sd == '0) ? FB_SEED : sd;
        else if (fire) ref_state = lfsr_next(ref_state);
        if (fire) pt_q.push_back(d);
        @(posedge clk);
        @(negedge clk);
        check(u0_ov == fire, (ld && v) ? "R4 load ignores data" : "R2 out_valid",
              {63'd0, u0_ov}, {63'd0, fire});
        if (fire)
            check(u0_od == exp_d, "R2/R3 ciphertext", {56'd0, u0_od}, {56'd0, exp_d});
        check(u1_ov == prev_fire, "R6 receiver valid", {63'd0, u1_ov}, {63'd0, prev_fire});
        if (u1_ov && prev_fire && pt_q.size() > 0) begin
            pt = pt_q.pop_front();
            check(u1_od == pt, "R6 recovered plaintext", {56'd0, u1_od}, {56'd0, pt});
        end
        prev_fire = fire;
        last_od   = u0_od;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++)
            cycle(($urandom_range(0, 3) != 0), W'($urandom), 1'b0, '0);
        cycle(1'b0, '0, 1'b0, '0);
        cycle(1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        int first_rep;
        ref_state = RST_SEED;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(u0_ov == 1'b0, "R1 out_valid after reset", {63'd0, u0_ov}, 64'd0);
        check(u0_ready == 1'b1, "R1 in_ready after reset", {63'd0, u0_ready}, 64'd1);
        check(u1_ov == 1'b0, "R1 receiver idle after reset", {63'd0, u1_ov}, 64'd0);
        @(negedge clk);

        // R1: first keystream word is the reset seed
        cycle(1'b1, 8'h00, 1'b0, '0);
        check(last_od == RST_SEED, "R1 first key word", {56'd0, last_od}, {56'd0, RST_SEED});

        // R2, R3, R6: random data with random stalls
        random_run(60);

        // R4: seed load with data offered at the same time
        cycle(1'b1, 8'hA5, 1'b1, 8'h3C);
        cycle(1'b1, 8'h00, 1'b0, '0);
        check(last_od == 8'h3C, "R4 seed loaded", {56'd0, last_od}, 64'h3C);
        random_run(40);

        // R5: zero seed replaced by fallback
        cycle(1'b0, '0, 1'b1, 8'h00);
        cycle(1'b1, 8'h00, 1'b0, '0);
        check(last_od == FB_SEED, "R5 zero seed substituted", {56'd0, last_od}, {56'd0, FB_SEED});
        random_run(40);

        // R7: full period from seed 01
        cycle(1'b0, '0, 1'b1, 8'h01);
        first_rep = -1;
        for (int i = 0; i < 256; i++) begin
            cycle(1'b1, 8'h00, 1'b0, '0);
            if (i > 0 && last_od == 8'h01 && first_rep < 0) first_rep = i;
            check(last_od != 8'h00, "R5 state never zero", {56'd0, last_od}, 64'h1);
        end
        check(first_rep == 255, "R7 period", 64'(first_rep), 64'd255);
        cycle(1'b0, '0, 1'b0, '0);
        cycle(1'b0, '0, 1'b0, '0);

        summary();
        $finish;
    end

endmodule